// File: doc/BRIEF.md
# Serial Port Timeslot Assigner

This block places three channel streams of a serial time-division port (two 8-bit bearer channels, called B1 and B2, and one 2-bit signalling channel, called D) onto a single data output at timeslots that software chooses. A data-clock strobe marks each bit period. A frame sync sampled on that strobe starts a frame, and a bit position counter runs from it. Each timeslot is two bit periods wide. Every channel compares the current position with the start of its assigned slot and claims the bit period when the position falls inside its window. The winning channel drives the output and enables the driver. When no channel claims the position, the output driver is released.

Software reaches the assigner through a small parallel register port. The port has a standard bank. An overlay bank sits on top of the low addresses of that bank and becomes visible only while a select bit in the highest standard register is set. The overlay holds the three slot numbers, the per-channel placement enables and a clock-disable field for two auxiliary clock outputs. A channel whose enable is clear keeps a fixed default slot. Both resets hide the overlay and clear every bit in it. Slot numbers, enables and channel data are captured only at a frame sync, so a frame is never built from a mix of old and new settings.

Top module: `tsa_top`

## Requirements
- R1: One timeslot spans two data-clock strobes (`dcl_en`). The strobe on which `fsync` is high is bit position 0, and timeslot n starts at bit position 2n. The output for a bit position appears in the clock cycle after its strobe and holds until the next strobe.
- R2: B1 and B2 each fill 8 consecutive bit positions and D fills 2. Each channel starts at the first bit position of its slot and is sent MSB first.
- R3: While the overlay is visible, address 0 holds the B1 slot, address 1 the B2 slot and address 2 the D slot. Each is an 8-bit read/write register.
- R4: Overlay address 3 holds the placement enables: bit 0 for B1, bit 1 for B2, bit 2 for D. A channel with its enable clear uses its default slot: B1 slot 0, B2 slot 4, D slot 8.
- R5: The overlay is visible while bit 0 of standard address 7 is 1. When it is visible, reads and writes to addresses 0 to 4 reach the overlay. Otherwise they reach the standard bank, and the standard contents are kept. Addresses 5 to 7 always reach the standard bank.
- R6: The hardware reset (`rst_n` low) and the software reset (`soft_rst` high for one cycle) both clear every overlay bit and the overlay-select bit.
- R7: Overlay address 4 bits 2:0 are clock disables. Both `aux_clk_en` bits are 1 unless all three disable bits are 1, in which case both are 0.
- R8: `dout_oe` is 0 on any bit position not claimed by a channel. It is also 0 before the first frame sync after reset.
- R9: Where channel windows overlap, B1 wins over B2, and B2 wins over D.
- R10: Slot numbers, enables and channel data (`b1_data`, `b2_data`, `d_data`) are captured on the frame-sync strobe. Register writes made during a frame change nothing until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Software reset pulse that clears the register banks |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| dcl_en | input | 1 | One-cycle strobe per data-clock bit period |
| fsync | input | 1 | Frame sync, sampled on `dcl_en` |
| b1_data | input | 8 | B1 channel byte for the next frame |
| b2_data | input | 8 | B2 channel byte for the next frame |
| d_data | input | 2 | D channel bits for the next frame |
| dout | output | 1 | Serial data out |
| dout_oe | output | 1 | Output driver enable |
| aux_clk_en | output | 2 | Enables for the two auxiliary clocks |

## Verification
Several properties are checked on every cycle. The driver stays off outside a frame. A frame sync always restarts the position at zero. Outputs and captured enables hold still between strobes and frame syncs. A software reset always hides the overlay and turns the auxiliary clocks back on. Other behaviour can only be shown by the bench scenarios: where each channel lands for a given set of slot numbers and default slots, bit order, which channel wins an overlap, how overlay and standard banks share addresses, and that a write made mid-frame is deferred. The bench compares every bit period against a model of the frame.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int SLOT_W   = 8;
  localparam int NCH      = 3;
  localparam int CH_B1    = 0;
  localparam int CH_B2    = 1;
  localparam int CH_D     = 2;
  localparam int OV_COUNT = 5;
  localparam int OV_CTL   = 3;
  localparam int OV_CLK   = 4;
  localparam int POS_W    = SLOT_W + 2;

  typedef struct packed {
    logic [NCH-1:0][SLOT_W-1:0] slot;
    logic [NCH-1:0]             en;
  } tsa_cfg_t;
endpackage

// File: rtl/tsa_regs.sv
module tsa_regs
  import tsa_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output tsa_cfg_t          cfg,
  output logic [2:0]        clk_dis,
  output logic              ov_sel
);
  localparam int NUM_STD = 1 << ADDR_W;
  localparam int SEL_IDX = NUM_STD - 1;

  logic [NUM_STD-1:0][7:0]  std_q, std_d;
  logic [OV_COUNT-1:0][7:0] ov_q, ov_d;

  assign ov_sel = std_q[SEL_IDX][0];

  always_comb begin
    std_d = std_q;
    ov_d  = ov_q;
    if (soft_rst) begin
      std_d = '0;
      ov_d  = '0;
    end else if (we) begin
      for (int i = 0; i < NUM_STD; i++)
        if (addr == ADDR_W'(i) && !(ov_sel && i < OV_COUNT)) std_d[i] = wdata;
      for (int i = 0; i < OV_COUNT; i++)
        if (ov_sel && addr == ADDR_W'(i)) ov_d[i] = wdata;
    end
  end

  always_comb begin
    rdata = std_q[addr];
    if (ov_sel)
      for (int i = 0; i < OV_COUNT; i++)
        if (addr == ADDR_W'(i)) rdata = ov_q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      std_q <= '0;
      ov_q  <= '0;
    end else begin
      std_q <= std_d;
      ov_q  <= ov_d;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_slot
    assign cfg.slot[c] = ov_q[c];
  end
  assign cfg.en  = ov_q[OV_CTL][NCH-1:0];
  assign clk_dis = ov_q[OV_CLK][2:0];
endmodule

// File: rtl/tsa_frame.sv
module tsa_frame
  import tsa_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dcl_en,
  input  logic                fsync,
  input  tsa_cfg_t            cfg_in,
  input  logic [NCH-1:0][7:0] din,
  output logic [POS_W-1:0]    pos,
  output logic                frame_act,
  output tsa_cfg_t            cfg_sh,
  output logic [NCH-1:0][7:0] dat_sh
);
  logic [POS_W-1:0]    pos_d;
  logic                act_d;
  tsa_cfg_t            cfg_d;
  logic [NCH-1:0][7:0] dat_d;

  always_comb begin
    pos_d = pos;
    act_d = frame_act;
    cfg_d = cfg_sh;
    dat_d = dat_sh;
    if (dcl_en) begin
      if (fsync) begin
        pos_d = '0;
        act_d = 1'b1;
        cfg_d = cfg_in;
        dat_d = din;
      end else if (frame_act && pos != '1) begin
        pos_d = pos + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos       <= '0;
      frame_act <= 1'b0;
      cfg_sh    <= '0;
      dat_sh    <= '0;
    end else begin
      pos       <= pos_d;
      frame_act <= act_d;
      cfg_sh    <= cfg_d;
      dat_sh    <= dat_d;
    end
  end
endmodule

// File: rtl/tsa_chsel.sv
module tsa_chsel
  import tsa_pkg::*;
#(
  parameter logic [SLOT_W-1:0] DEF_B1_SLOT = 8'd0,
  parameter logic [SLOT_W-1:0] DEF_B2_SLOT = 8'd4,
  parameter logic [SLOT_W-1:0] DEF_D_SLOT  = 8'd8
) (
  input  logic [POS_W-1:0]    pos,
  input  logic                frame_act,
  input  tsa_cfg_t            cfg_sh,
  input  logic [NCH-1:0][7:0] dat_sh,
  output logic                dout,
  output logic                dout_oe,
  output logic [NCH-1:0]      hit
);
  logic [NCH-1:0] bit_v;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int LEN = (c == CH_D) ? 2 : 8;
    localparam logic [SLOT_W-1:0] DEF =
      (c == CH_B1) ? DEF_B1_SLOT : (c == CH_B2) ? DEF_B2_SLOT : DEF_D_SLOT;
    logic [SLOT_W-1:0] slot_eff;
    logic [POS_W-1:0]  base;
    logic [POS_W-1:0]  off;
    logic [2:0]        idx;

    assign slot_eff = cfg_sh.en[c] ? cfg_sh.slot[c] : DEF;
    assign base     = POS_W'({slot_eff, 1'b0});
    assign off      = pos - base;
    assign hit[c]   = frame_act && (pos >= base) && (off < POS_W'(LEN));
    assign idx      = 3'(LEN - 1) - off[2:0];
    assign bit_v[c] = dat_sh[c][idx];
  end

  always_comb begin
    dout_oe = |hit;
    dout    = 1'b0;
    for (int c = NCH - 1; c >= 0; c--)
      if (hit[c]) dout = bit_v[c];
  end
endmodule

// File: rtl/tsa_top.sv
module tsa_top
  import tsa_pkg::*;
#(
  parameter int                ADDR_W      = 3,
  parameter logic [SLOT_W-1:0] DEF_B1_SLOT = 8'd0,
  parameter logic [SLOT_W-1:0] DEF_B2_SLOT = 8'd4,
  parameter logic [SLOT_W-1:0] DEF_D_SLOT  = 8'd8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              dcl_en,
  input  logic              fsync,
  input  logic [7:0]        b1_data,
  input  logic [7:0]        b2_data,
  input  logic [1:0]        d_data,
  output logic              dout,
  output logic              dout_oe,
  output logic [1:0]        aux_clk_en
);
  logic                rst_meta, rst_n_sync;
  tsa_cfg_t            cfg, cfg_sh;
  logic [2:0]          clk_dis;
  logic                ov_sel;
  logic [NCH-1:0][7:0] din, dat_sh;
  logic [POS_W-1:0]    pos;
  logic                frame_act;
  logic [NCH-1:0]      hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  assign din[CH_B1] = b1_data;
  assign din[CH_B2] = b2_data;
  assign din[CH_D]  = {6'b0, d_data};

  tsa_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n_sync), .soft_rst(soft_rst), .we(reg_we),
    .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .cfg(cfg), .clk_dis(clk_dis), .ov_sel(ov_sel)
  );

  tsa_frame u_frame (
    .clk(clk), .rst_n(rst_n_sync), .dcl_en(dcl_en), .fsync(fsync),
    .cfg_in(cfg), .din(din), .pos(pos), .frame_act(frame_act),
    .cfg_sh(cfg_sh), .dat_sh(dat_sh)
  );

  tsa_chsel #(
    .DEF_B1_SLOT(DEF_B1_SLOT), .DEF_B2_SLOT(DEF_B2_SLOT), .DEF_D_SLOT(DEF_D_SLOT)
  ) u_chsel (
    .pos(pos), .frame_act(frame_act), .cfg_sh(cfg_sh), .dat_sh(dat_sh),
    .dout(dout), .dout_oe(dout_oe), .hit(hit)
  );

  assign aux_clk_en = {2{~&clk_dis}};
endmodule

// File: rtl/tsa_chk.sv
module tsa_chk
  import tsa_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             soft_rst,
  input logic             dcl_en,
  input logic             fsync,
  input logic             dout,
  input logic             dout_oe,
  input logic [1:0]       aux_clk_en,
  input logic             frame_act,
  input logic [POS_W-1:0] pos,
  input logic             ov_sel,
  input tsa_cfg_t         cfg_sh
);
  AST_NO_OE_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |-> !dout_oe); // R8
  AST_SYNC_RESTARTS_POS: assert property (@(posedge clk) disable iff (!rst_n)
    (dcl_en && fsync) |=> (pos == '0 && frame_act)); // R1
  AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
    !dcl_en |=> ($stable(dout) && $stable(dout_oe))); // R1
  AST_CFG_ONLY_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !(dcl_en && fsync) |=> $stable(cfg_sh)); // R10
  AST_SOFT_RST_HIDES: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !ov_sel); // R6
  AST_SOFT_RST_CLKS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (aux_clk_en == 2'b11)); // R7
endmodule

bind tsa_top tsa_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .soft_rst(soft_rst), .dcl_en(dcl_en),
  .fsync(fsync), .dout(dout), .dout_oe(dout_oe), .aux_clk_en(aux_clk_en),
  .frame_act(frame_act), .pos(pos), .ov_sel(ov_sel), .cfg_sh(cfg_sh)
);

// File: tb/tsa_top_tb.sv
module tsa_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       dcl_en = 1'b0;
  logic       fsync = 1'b0;
  logic [7:0] b1_data = '0;
  logic [7:0] b2_data = '0;
  logic [1:0] d_data = '0;
  logic       dout, dout_oe;
  logic [1:0] aux_clk_en;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // bench model of the assigner
  int  pend_slot[3];
  bit  pend_en[3];
  int  act_slot[3];
  bit  act_en[3];
  logic [7:0] act_dat[3];
  bit  in_frame = 0;
  int  mpos = 0;
  string cur_tag = "R8";

  bit    exp_oe_q[$];
  bit    exp_d_q[$];
  string exp_tag_q[$];

  always #4 clk = ~clk;

  tsa_top u_dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dcl_en(dcl_en), .fsync(fsync), .b1_data(b1_data), .b2_data(b2_data),
    .d_data(d_data), .dout(dout), .dout_oe(dout_oe), .aux_clk_en(aux_clk_en)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input int a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = 3'(a);
    #1;
    check(reg_rdata == 8'(exp), tag, reg_rdata, exp);
  endtask

  function automatic void model(input int p, output bit oe, output bit d);
    int defs[3] = '{0, 4, 8};
    int lens[3] = '{8, 8, 2};
    oe = 0; d = 0;
    if (!in_frame) return;
    for (int c = 0; c < 3; c++) begin
      int base = 2 * (act_en[c] ? act_slot[c] : defs[c]);
      if (p >= base && p - base < lens[c]) begin
        oe = 1; d = act_dat[c][lens[c] - 1 - (p - base)];
        return;
      end
    end
  endfunction

  // driver: one data-clock strobe, pushes the expected bit
  task automatic tick(input bit fs);
    bit eo, ed;
    @(negedge clk);
    dcl_en = 1'b1; fsync = fs;
    if (fs) begin
      in_frame = 1; mpos = 0;
      for (int c = 0; c < 3; c++) begin
        act_slot[c] = pend_slot[c]; act_en[c] = pend_en[c];
      end
      act_dat[0] = b1_data; act_dat[1] = b2_data; act_dat[2] = {6'b0, d_data};
    end else if (in_frame) begin
      mpos++;
    end
    model(mpos, eo, ed);
    exp_oe_q.push_back(eo); exp_d_q.push_back(ed); exp_tag_q.push_back(cur_tag);
    @(negedge clk);
    dcl_en = 1'b0; fsync = 1'b0;
  endtask

  task automatic frame(input int n);
    tick(1'b1);
    for (int k = 1; k < n; k++) tick(1'b0);
  endtask

  task automatic set_ctl(input int en);
    reg_wr(3, en);
    for (int c = 0; c < 3; c++) pend_en[c] = en[c];
  endtask

  task automatic set_slot(input int c, input int s);
    reg_wr(c, s);
    pend_slot[c] = s;
  endtask

  // monitor: pops one expected item per strobe
  always @(posedge clk) begin
    bit    was_tick, eo, ed;
    string tg;
    was_tick = dcl_en;
    #2;
    if (was_tick && exp_oe_q.size() > 0) begin
      eo = exp_oe_q.pop_front(); ed = exp_d_q.pop_front(); tg = exp_tag_q.pop_front();
      check(dout_oe == eo && (!eo || dout == ed), tg, {dout_oe, dout}, {eo, ed});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < 3; c++) begin pend_slot[c] = 0; pend_en[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6: hardware reset state
    check(dout_oe == 1'b0, "R8 oe after reset", dout_oe, 0);
    check(aux_clk_en == 2'b11, "R7 clocks after reset", aux_clk_en, 3);
    reg_rd(7, 0, "R6 select clear after reset");

    // R8: strobes before any frame sync
    cur_tag = "R8";
    repeat (4) tick(1'b0);

    // R5: overlay vs standard bank
    reg_wr(0, 8'h5A);
    reg_rd(0, 8'h5A, "R5 standard bank write");
    reg_wr(7, 1);
    reg_rd(0, 0, "R6 overlay cleared at reset");
    set_slot(0, 3);
    reg_rd(0, 3, "R3 B1 slot readback");
    set_slot(1, 12);
    reg_rd(1, 12, "R3 B2 slot readback");
    reg_wr(7, 0);
    reg_rd(0, 8'h5A, "R5 standard kept under overlay");
    reg_wr(7, 1);
    reg_rd(7, 1, "R5 address 7 stays standard");

    // R7: clock disables
    reg_wr(4, 3);
    #1 check(aux_clk_en == 2'b11, "R7 partial disable", aux_clk_en, 3);
    reg_wr(4, 7);
    #1 check(aux_clk_en == 2'b00, "R7 full disable", aux_clk_en, 0);
    reg_wr(4, 0);
    #1 check(aux_clk_en == 2'b11, "R7 re-enable", aux_clk_en, 3);

    // R4: enables clear, default slots
    b1_data = 8'hA5; b2_data = 8'h3C; d_data = 2'b10;
    cur_tag = "R4";
    frame(22);

    // R2: programmed slots, MSB first
    set_slot(0, 3); set_slot(1, 8); set_slot(2, 1);
    set_ctl(7);
    b1_data = 8'h96; b2_data = 8'hE1; d_data = 2'b01;
    cur_tag = "R2";
    frame(26);

    // R9: overlapping windows
    set_slot(0, 2); set_slot(1, 4); set_slot(2, 5);
    b1_data = 8'hF0; b2_data = 8'h0F; d_data = 2'b11;
    cur_tag = "R9";
    frame(18);

    // R10: mid-frame writes wait for the next frame sync
    set_slot(0, 6); set_slot(1, 0); set_ctl(3);
    b1_data = 8'hC3; b2_data = 8'h5A; d_data = 2'b10;
    cur_tag = "R10";
    tick(1'b1);
    repeat (4) tick(1'b0);
    set_slot(0, 1); set_ctl(4); set_slot(2, 2);
    b1_data = 8'h00;
    repeat (14) tick(1'b0);
    cur_tag = "R10 new frame";
    frame(20);

    // R1: short frame restarted by an early sync
    cur_tag = "R1";
    set_ctl(1); set_slot(0, 1);
    b1_data = 8'h81;
    tick(1'b1); repeat (3) tick(1'b0);
    frame(12);

    // R6: software reset
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
    for (int c = 0; c < 3; c++) begin pend_slot[c] = 0; pend_en[c] = 0; end
    check(aux_clk_en == 2'b11, "R6 clocks after soft reset", aux_clk_en, 3);
    reg_rd(7, 0, "R6 select cleared by soft reset");
    reg_wr(7, 1);
    reg_rd(3, 0, "R6 enables cleared by soft reset");
    reg_rd(2, 0, "R6 D slot cleared by soft reset");

    repeat (4) @(negedge clk);
    check(exp_oe_q.size() == 0, "R1 scoreboard drained", exp_oe_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule